// File: doc/BRIEF.md
# Queued SPI Transfer Sequencer

The sequencer sits between a host register port and a separate SPI shift engine and walks a list of transfers with no processor help. Each of its sixteen queue slots holds a transmit word, a chip-select number, a transfer length and a pause measured in system clocks. For every slot it visits, it hands those fields to the engine with a one-cycle start pulse and waits for the engine's done pulse. It then stores the returned word back into that slot's receive half and holds off for the slot's pause before it moves on.

The host sets a first and a last slot and turns the sequencer on. Slots are visited in ascending order, modulo sixteen, so a range may wrap past slot 15. When the last slot finishes, the sequencer either halts and raises a completion flag or, with the repeat option set, jumps back to the first slot and keeps polling. Turning the enable off never cuts a transfer short: the slot in progress finishes, its received word is stored, and the sequencer then goes idle.

Top module: `spi_queue_sequencer`

## Requirements
- R1: After reset there is no start pulse, the status word (bits 3:0 current slot, bit 4 completion flag, bit 5 busy) reads 0, and every receive word reads 0.
- R2: Writing the control word at address 0x20 (bit 0 enable, bit 1 repeat, bits 7:4 first slot, bits 11:8 last slot) with enable set from idle produces a start pulse two cycles after the write. The pulse lasts one cycle and carries the first slot's transmit word, chip select and length.
- R3: Slots are issued in ascending order modulo 16 from the first slot to the last slot, and a last slot below the first slot wraps past slot 15. A slot's configuration word is written at address i as bits 15:0 transmit, 17:16 chip select, 22:18 length, 30:23 pause.
- R4: The word on the engine's receive input in the done cycle is stored into the issuing slot and can be read at address 0x10+i.
- R5: If the done pulse comes in cycle c for a slot with pause d, the next start pulse comes in cycle c+d+4.
- R6: Without repeat, finishing the last slot halts the sequencer. The status then shows the completion flag set, busy clear and the current slot equal to the last slot, and no further start pulse occurs.
- R7: With repeat, finishing the last slot restarts at the first slot with no pause beyond its own. The completion flag stays clear and busy stays set.
- R8: Clearing enable during a transfer lets that transfer finish and store its receive word. No further start pulse follows, and the status then shows busy clear with the current slot unchanged.
- R9: A host configuration write to a slot in the same cycle that the slot's receive word is stored takes effect on both halves. The new transmit word is used the next time the slot is issued.
- R10: From a halt, clearing and then setting enable restarts at the first slot and clears the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from address |
| eng_start | output | 1 | One-cycle request to the SPI engine |
| eng_tx | output | 16 | Transmit word for the requested transfer |
| eng_cs | output | 2 | Chip-select number for the requested transfer |
| eng_len | output | 5 | Length code for the requested transfer |
| eng_done | input | 1 | Engine finished the current transfer |
| eng_rx | input | 16 | Word received by the engine, valid with eng_done |

## Verification
Two writes can reach the queue in the same cycle: the sequencer storing a received word, and the host rewriting that same slot's configuration. The bench waits for a done pulse on a chosen slot in a repeating run and then times a host configuration write so that both land on the same clock edge. It reads back both halves of the slot at once. The per-cycle model then requires that the slot's next issue carries the new transmit word.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  parameter int unsigned TX_W   = 16;
  parameter int unsigned CS_W   = 2;
  parameter int unsigned LEN_W  = 5;
  parameter int unsigned DLY_W  = 8;
  parameter int unsigned HOST_W = 32;

  typedef struct packed {
    logic [DLY_W-1:0] dly;
    logic [LEN_W-1:0] len;
    logic [CS_W-1:0]  cs;
    logic [TX_W-1:0]  tx;
  } entry_cfg_t;

  localparam int unsigned CFG_W = $bits(entry_cfg_t);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_WB, S_DELAY, S_NEXT, S_HALT
  } seq_state_e;

  // slot following p in a ring of depth slots
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p + 1) % depth;
  endfunction
endpackage

// File: rtl/qseq_queue.sv
module qseq_queue import qseq_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PTR_W-1:0] cfg_idx,
  input  entry_cfg_t       cfg_wdata,
  input  logic             wb_en,
  input  logic [PTR_W-1:0] wb_idx,
  input  logic [TX_W-1:0]  wb_data,
  input  logic [PTR_W-1:0] seq_idx,
  output entry_cfg_t       seq_cfg,
  input  logic [PTR_W-1:0] host_idx,
  output entry_cfg_t       host_cfg,
  output logic [TX_W-1:0]  host_rx
);
  entry_cfg_t      cfg_all [DEPTH];
  logic [TX_W-1:0] rx_all  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    entry_cfg_t      cfg_r;
    logic [TX_W-1:0] rx_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_r <= '0;
        rx_r  <= '0;
      end else begin
        if (cfg_we && cfg_idx == PTR_W'(i)) cfg_r <= cfg_wdata;
        if (wb_en && wb_idx == PTR_W'(i))   rx_r  <= wb_data;
      end
    end
    assign cfg_all[i] = cfg_r;
    assign rx_all[i]  = rx_r;
  end

  assign seq_cfg  = cfg_all[seq_idx];
  assign host_cfg = cfg_all[host_idx];
  assign host_rx  = rx_all[host_idx];

  // R4: a stored receive word is visible in its slot on the next cycle
  p_wb_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> rx_all[$past(wb_idx)] == $past(wb_data));

  // R9: a host configuration write lands even when a writeback hits the same slot
  p_cfg_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_all[$past(cfg_idx)] == $past(cfg_wdata));
endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl import qseq_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wrap,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [PTR_W-1:0] end_ptr,
  input  logic [DLY_W-1:0] cur_dly,
  input  logic             eng_done,
  input  logic [TX_W-1:0]  eng_rx,
  output logic             eng_start,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             wb_en,
  output logic [TX_W-1:0]  wb_data,
  output logic             done_flag,
  output logic             busy
);
  seq_state_e       st;
  logic [DLY_W-1:0] dcnt;
  logic [TX_W-1:0]  rx_hold;
  logic             at_end;
  logic             in_halt;

  assign at_end = (cur_ptr == end_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_ptr   <= '0;
      dcnt      <= '0;
      rx_hold   <= '0;
      done_flag <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (enable) begin
          st        <= S_ISSUE;
          cur_ptr   <= start_ptr;
          done_flag <= 1'b0;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (eng_done) begin
          rx_hold <= eng_rx;
          st      <= S_WB;
        end
        S_WB: begin
          dcnt <= cur_dly;
          st   <= S_DELAY;
        end
        S_DELAY: if (dcnt == '0) st <= S_NEXT;
                 else            dcnt <= dcnt - 1'b1;
        S_NEXT: begin
          if (!enable) st <= S_IDLE;
          else if (at_end && !wrap) begin
            done_flag <= 1'b1;
            st        <= S_HALT;
          end else begin
            cur_ptr <= at_end ? start_ptr
                              : PTR_W'(ptr_step(int'(cur_ptr), DEPTH));
            st      <= S_ISSUE;
          end
        end
        S_HALT: if (!enable) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign eng_start = (st == S_ISSUE);
  assign wb_en     = (st == S_WB);
  assign wb_data   = rx_hold;
  assign in_halt   = (st == S_HALT);
  assign busy      = (st != S_IDLE) && !in_halt;

  // R2: the engine request is a single-cycle pulse
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R4: writeback only follows an accepted done pulse
  p_wb_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(st == S_WAIT && eng_done));

  // R5: the pause counter starts from the slot's pause value
  p_pause_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> (st == S_DELAY && dcnt == $past(cur_dly)));

  // R6: a halt is only reached on the last slot with repeat off
  p_halt_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_halt) |-> (cur_ptr == $past(end_ptr) && !$past(wrap) && done_flag));

  // R7: with repeat on, the last slot leads straight back to the first slot
  p_wrap_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NEXT && enable && wrap && at_end) |=>
      (eng_start && cur_ptr == $past(start_ptr)));

  // R8: a disabled sequencer stops at the slot boundary and keeps its pointer
  p_clean_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NEXT && !enable) |=> (st == S_IDLE && $stable(cur_ptr)));
endmodule

// File: rtl/spi_queue_sequencer.sv
module spi_queue_sequencer import qseq_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = PTR_W + 2,
  localparam int unsigned START_LSB = 4,
  localparam int unsigned END_LSB   = START_LSB + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              eng_start,
  output logic [TX_W-1:0]   eng_tx,
  output logic [CS_W-1:0]   eng_cs,
  output logic [LEN_W-1:0]  eng_len,
  input  logic              eng_done,
  input  logic [TX_W-1:0]   eng_rx
);
  localparam logic [1:0] RG_CFG = 2'd0, RG_RX = 2'd1, RG_CTRL = 2'd2;

  logic [1:0]       region;
  logic [PTR_W-1:0] host_idx;
  logic             en_q, wrap_q;
  logic [PTR_W-1:0] first_q, last_q, cur_ptr;
  logic             wb_en, done_flag, busy;
  logic [TX_W-1:0]  wb_data, host_rx;
  entry_cfg_t       seq_cfg, host_cfg;
  logic             unused_bits;

  assign region      = host_addr[ADDR_W-1 -: 2];
  assign host_idx    = host_addr[PTR_W-1:0];
  assign unused_bits = ^host_wdata[HOST_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      wrap_q  <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else if (host_we && region == RG_CTRL) begin
      en_q    <= host_wdata[0];
      wrap_q  <= host_wdata[1];
      first_q <= host_wdata[START_LSB +: PTR_W];
      last_q  <= host_wdata[END_LSB +: PTR_W];
    end
  end

  qseq_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (host_we && region == RG_CFG),
    .cfg_idx  (host_idx),
    .cfg_wdata(entry_cfg_t'(host_wdata[CFG_W-1:0])),
    .wb_en    (wb_en),
    .wb_idx   (cur_ptr),
    .wb_data  (wb_data),
    .seq_idx  (cur_ptr),
    .seq_cfg  (seq_cfg),
    .host_idx (host_idx),
    .host_cfg (host_cfg),
    .host_rx  (host_rx)
  );

  qseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (en_q),
    .wrap     (wrap_q),
    .start_ptr(first_q),
    .end_ptr  (last_q),
    .cur_dly  (seq_cfg.dly),
    .eng_done (eng_done),
    .eng_rx   (eng_rx),
    .eng_start(eng_start),
    .cur_ptr  (cur_ptr),
    .wb_en    (wb_en),
    .wb_data  (wb_data),
    .done_flag(done_flag),
    .busy     (busy)
  );

  assign eng_tx  = seq_cfg.tx;
  assign eng_cs  = seq_cfg.cs;
  assign eng_len = seq_cfg.len;

  always_comb begin
    host_rdata = '0;
    case (region)
      RG_CFG: host_rdata = HOST_W'(host_cfg);
      RG_RX:  host_rdata = HOST_W'(host_rx);
      RG_CTRL: begin
        host_rdata[0] = en_q;
        host_rdata[1] = wrap_q;
        host_rdata[START_LSB +: PTR_W] = first_q;
        host_rdata[END_LSB +: PTR_W]   = last_q;
      end
      default: begin
        host_rdata[PTR_W-1:0] = cur_ptr;
        host_rdata[PTR_W]     = done_flag;
        host_rdata[PTR_W+1]   = busy;
      end
    endcase
  end
endmodule

// File: tb/spi_queue_sequencer_tb.sv
`timescale 1ns/1ps
module spi_queue_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        eng_start;
  logic [15:0] eng_tx;
  logic [1:0]  eng_cs;
  logic [4:0]  eng_len;
  logic        eng_done = 1'b0;
  logic [15:0] eng_rx = '0;

  always #2.5 clk = ~clk;

  spi_queue_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_start(eng_start),
    .eng_tx(eng_tx), .eng_cs(eng_cs), .eng_len(eng_len),
    .eng_done(eng_done), .eng_rx(eng_rx)
  );

  // configuration model, owned by the main sequence
  logic [15:0] m_tx  [16];
  logic [1:0]  m_cs  [16];
  logic [4:0]  m_len [16];
  logic [7:0]  m_dly [16];
  int m_first = 0, m_last = 0;
  bit m_wrap = 0;
  int arm_seq = 0, stop_seq = 0;
  int err_cnt = 0, chk_cnt = 0;

  // per-cycle model, owned by the monitor
  logic [15:0] m_rx [16];
  bit m_expect = 0;
  int m_idx = 0, m_wait = -1, done_cd = 0, issued = 0;
  int mon_starts = 0, arm_seen = 0, stop_seen = 0;
  int mon_err = 0, mon_chk = 0;
  int cycles = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    chk_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mchk(bit ok, string req, string what, int act, int exp);
    mon_chk++;
    if (!ok) begin
      mon_err++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h",
               req, what, cycles, act, exp);
    end
  endtask

  // engine stand-in and reference model, compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_start;
      if (m_wait > 0) m_wait--;
      exp_start = m_expect && (m_wait == 0);
      mchk(eng_start == exp_start, "R5", "start pulse timing",
           int'(eng_start), int'(exp_start));
      eng_done = 1'b0;
      if (done_cd > 0) begin
        done_cd--;
        if (done_cd == 0) begin
          eng_done   = 1'b1;
          eng_rx     = {4'hC, 4'(issued), 8'(mon_starts)};
          m_rx[issued] = eng_rx;
          m_wait     = int'(m_dly[issued]) + 4;
        end
      end
      if (eng_start) begin
        mchk(eng_tx == m_tx[m_idx], "R3", "issued transmit word", int'(eng_tx), int'(m_tx[m_idx]));
        mchk(eng_cs == m_cs[m_idx], "R2", "issued chip select", int'(eng_cs), int'(m_cs[m_idx]));
        mchk(eng_len == m_len[m_idx], "R2", "issued length", int'(eng_len), int'(m_len[m_idx]));
        issued = m_idx;
        mon_starts++;
        done_cd = 2;
        m_wait  = -1;
        if (m_idx == m_last) begin
          if (m_wrap) m_idx = m_first;
          else        m_expect = 0;
        end else m_idx = (m_idx + 1) % 16;
      end
      if (arm_seq != arm_seen) begin
        arm_seen = arm_seq;
        m_expect = 1;
        m_idx    = m_first;
        m_wait   = 1;
      end
      if (stop_seq != stop_seen) begin
        stop_seen = stop_seq;
        m_expect  = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      $display("FAIL watchdog: actual=%0d expected=below 20000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks",
               err_cnt + mon_err + 1, chk_cnt + mon_chk + 1);
      $finish;
    end
  end

  task automatic host_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(logic [5:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic cfg_write(int i, logic [15:0] tx, logic [1:0] cs, logic [4:0] len, logic [7:0] dly);
    m_tx[i] = tx; m_cs[i] = cs; m_len[i] = len; m_dly[i] = dly;
    host_write(6'(i), {1'b0, dly, len, cs, tx});
  endtask

  // control write; the model is armed just after the write is driven
  task automatic ctrl_write(bit en, bit wr, int first, int last, bit arm);
    @(negedge clk);
    host_we = 1'b1; host_addr = 6'h20;
    host_wdata = {20'h0, 4'(last), 4'(first), 2'b00, wr, en};
    #1;
    m_first = first; m_last = last; m_wrap = wr;
    if (arm) arm_seq++;
    if (!en) stop_seq++;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 16; i++) begin
      m_tx[i] = '0; m_cs[i] = '0; m_len[i] = '0; m_dly[i] = '0; m_rx[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    host_read(6'h30, rd); chk(rd == 32'h0, "R1", "status after reset", rd, 0);
    host_read(6'h13, rd); chk(rd == 32'h0, "R1", "receive word after reset", rd, 0);
    chk(eng_start == 1'b0, "R1", "start after reset", int'(eng_start), 0);

    for (int i = 0; i < 16; i++)
      cfg_write(i, 16'hA000 + 16'(i * 16'h111), 2'(i % 4), 5'(i + 3), 8'(i % 3));
    host_read(6'h05, rd);
    chk(rd == {1'b0, m_dly[5], m_len[5], m_cs[5], m_tx[5]}, "R3", "slot config readback",
        rd, {1'b0, m_dly[5], m_len[5], m_cs[5], m_tx[5]});

    // R2, R3, R4, R5, R6: one pass over slots 2..5
    ctrl_write(1, 0, 2, 5, 1);
    wait_cyc(70);
    host_read(6'h30, rd); chk(rd == 32'h15, "R6", "status after halt", rd, 32'h15);
    for (int i = 2; i <= 5; i++) begin
      host_read(6'(16 + i), rd);
      chk(rd[15:0] == m_rx[i], "R4", "stored receive word", rd, m_rx[i]);
    end
    chk(mon_starts == 4, "R6", "starts in one pass", mon_starts, 4);

    // R10, R3: restart over a range that wraps past slot 15
    ctrl_write(0, 0, 14, 1, 0);
    ctrl_write(1, 0, 14, 1, 1);
    wait_cyc(4);
    host_read(6'h30, rd);
    chk(rd[5:4] == 2'b10, "R10", "busy set and flag cleared on restart", rd[5:4], 2);
    wait_cyc(70);
    host_read(6'h30, rd); chk(rd == 32'h11, "R10", "status after second halt", rd, 32'h11);
    host_read(6'h1F, rd); chk(rd[15:0] == m_rx[15], "R3", "slot 15 visited", rd, m_rx[15]);
    host_read(6'h10, rd); chk(rd[15:0] == m_rx[0], "R3", "slot 0 visited", rd, m_rx[0]);
    chk(mon_starts == 8, "R3", "starts after wrapped range", mon_starts, 8);

    // R7: repeating run over slots 6..8
    ctrl_write(0, 0, 6, 8, 0);
    ctrl_write(1, 1, 6, 8, 1);
    wait_cyc(80);
    host_read(6'h30, rd);
    chk(rd[5:4] == 2'b10, "R7", "busy, no flag while repeating", rd[5:4], 2);
    chk(mon_starts >= 14, "R7", "repeated starts", mon_starts, 14);

    // R9: host config write in the same cycle as the writeback of slot 7
    do begin @(negedge clk); #1; end while (!(eng_done && issued == 7));
    cfg_write(7, 16'h7E57, 2'd2, 5'd30, m_dly[7]);
    host_read(6'h17, rd); chk(rd[15:0] == m_rx[7], "R9", "receive half after collision", rd, m_rx[7]);
    host_read(6'h07, rd);
    chk(rd[15:0] == 16'h7E57, "R9", "config half after collision", rd[15:0], 16'h7E57);
    wait_cyc(40);

    // R8: stop while slot 8 is in flight
    do begin @(negedge clk); #1; end while (!(eng_start && issued == 8));
    ctrl_write(0, 1, 6, 8, 0);
    wait_cyc(30);
    host_read(6'h30, rd); chk(rd == 32'h08, "R8", "status after stop", rd, 32'h08);
    host_read(6'h18, rd); chk(rd[15:0] == m_rx[8], "R8", "last transfer stored", rd, m_rx[8]);
    wait_cyc(10);

    $display("  Result: errors=%0d of %0d checks", err_cnt + mon_err, chk_cnt + mon_chk);
    $finish;
  end
endmodule